// File: doc/BRIEF.md
# Asynchronous Local Bus Register Slave

This block connects a small register bank to a processor's parallel local bus when no bus clock reaches the chip. It runs entirely on an internal clock about three times faster than the bus. Chip select is the only pin treated as asynchronous, and it passes through a two-flop synchronizer. The address-phase strobe, the write strobe, the address and the write data are sampled into a plain delay pipeline with no synchronizers. Their values are trusted only at moments when the bus protocol guarantees they are stable.

The address-phase strobe is high during the address phase and low during the data phase. The block latches the word index on the falling edge of the sampled strobe and keeps it through the data phase.

A static parameter selects how write data is captured:
- **Settle mode:** capture happens once a settle count has elapsed after chip select is seen.
- **Trailing-edge mode:** on the rising (trailing) edge of the write strobe, the block writes the data sampled a fixed number of cycles earlier.

Reads return the selected word. The block asks the pad to drive the data bus only while output enable and chip select are both asserted. The pad's tri-state buffer sits outside the block and is controlled by `bus_data_oe`.

Top module: `lbus_async_slave`

## Requirements
- R1: After reset every register word reads as zero and `bus_data_oe` is low.
- R2: The word index is taken from the address sampled just before the registered address-phase strobe falls (1 to 0). Address pin changes during the data phase do not alter which word is read or written.
- R3: The bank holds 16 words. A word is selected by address bits [3:0], and address bits [23:4] have no effect.
- R4: In settle mode, the write takes the data on the pins once synchronized chip select has been active for the settle count (default 10 cycles). It does so at the first such cycle in which the active-low write strobe is low.
- R5: In trailing-edge mode, the write strobe rising edge is detected between pipeline stages 0 and 1. The written word is the data held in pipeline stage 3, which is three cycles older than stage 0.
- R6: At most one word is written per chip-select cycle, whether the write strobe is held low for many cycles or pulsed more than once.
- R7: With chip select (active low) high, write strobe activity writes nothing.
- R8: `bus_data_oe` is high only while `bus_oe_n` and `bus_cs_n` are both low. While it is high, `bus_data_out` carries the selected word.
- R9: When `bus_cs_n` or `bus_oe_n` goes high, `bus_data_oe` is low within one internal clock.
- R10: Chip select passes through two flops. `bus_data_oe` cannot rise sooner than two clock edges after `bus_cs_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, about three times the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| bus_ale | input | 1 | Address-phase strobe: high for the address phase, low for the data phase |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_cs_n | input | 1 | Chip select, active low, asynchronous |
| bus_addr | input | 24 | Bus address |
| bus_data_in | input | 32 | Data bus as seen at the pad input |
| bus_data_out | output | 32 | Read data toward the pad driver |
| bus_data_oe | output | 1 | Pad driver enable; low means high impedance |

## Verification
The bench builds two instances side by side and drives both from the same pins.
- The first keeps the defaults: settle mode, a 10-cycle settle count, a 4-stage pipeline and 16 words.
- The second selects trailing-edge mode with a 4-stage pipeline and a 3-cycle look-back.

With both modes on one stimulus, one long write strobe whose data changes partway through must land as different words in the two instances. Double strobes, unselected strobes and garbage address values driven during the data phase then bring the single-write, no-write and address-hold rules within reach for both capture methods at once.

// File: rtl/lbus_pkg.sv
`timescale 1ns/1ps
package lbus_pkg;

    localparam int BUS_AW = 24;
    localparam int BUS_DW = 32;

    typedef enum logic {
        CAP_SETTLE = 1'b0,
        CAP_TRAIL  = 1'b1
    } cap_mode_e;

    // One sample of the bus pins that go through the plain delay pipeline
    typedef struct packed {
        logic              ale;
        logic              we_n;
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
    } pin_snap_t;

    // True when a level goes from 0 (older sample) to 1 (newer sample)
    function automatic logic went_high(input logic older, input logic newer);
        return ~older & newer;
    endfunction

endpackage

// File: rtl/lbus_sync2.sv
`timescale 1ns/1ps
module lbus_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/lbus_pipe.sv
`timescale 1ns/1ps
module lbus_pipe #(
    parameter int             W       = 8,
    parameter int             DEPTH   = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [W-1:0]              d,
    output logic [DEPTH-1:0][W-1:0]   taps
);
    // taps[0] is the newest sample, taps[DEPTH-1] the oldest
    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= {DEPTH{RST_VAL}};
        end else begin
            taps <= {taps[DEPTH-2:0], d};
        end
    end
endmodule

// File: rtl/lbus_capture.sv
`timescale 1ns/1ps
module lbus_capture
    import lbus_pkg::*;
#(
    parameter cap_mode_e MODE          = CAP_SETTLE,
    parameter int        DEPTH         = 4,
    parameter int        LOOKBACK      = 3,
    parameter int        SETTLE_CYCLES = 10,
    parameter int        IDX_W         = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  pin_snap_t         taps [DEPTH],
    output logic [IDX_W-1:0]  idx_q,
    output logic              wr_en,
    output logic [BUS_DW-1:0] wr_data
);
    logic ale_fall;
    logic fire;
    logic done_q;

    // Phase strobe falls: older sample high, newer sample low
    assign ale_fall = went_high(~taps[1].ale, ~taps[0].ale);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (ale_fall) begin
            idx_q <= taps[1].addr[IDX_W-1:0];
        end
    end

    generate
        if (MODE == CAP_SETTLE) begin : g_settle
            localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
            localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || !cs_act) begin
                    cnt_q <= '0;
                end else if (cnt_q != CNT_LAST) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign fire    = cs_act && (cnt_q == CNT_LAST) && !taps[0].we_n;
            assign wr_data = taps[0].data;
        end else begin : g_trail
            assign fire    = cs_act && went_high(taps[1].we_n, taps[0].we_n);
            assign wr_data = taps[LOOKBACK].data;
        end
    endgenerate

    assign wr_en = fire && !done_q;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            done_q <= 1'b0;
        end else if (wr_en) begin
            done_q <= 1'b1;
        end
    end

    // Fold pipeline bits that a given mode leaves untouched
    logic [$bits(pin_snap_t)-1:0] tap_fold;
    always_comb begin
        tap_fold = '0;
        for (int i = 0; i < DEPTH; i++) begin
            tap_fold = tap_fold ^ taps[i];
        end
    end
    logic unused_taps;
    assign unused_taps = ^tap_fold;

    // R2: the word index only moves on a phase-strobe fall
    a_r2_index_hold: assert property (@(posedge clk) disable iff (rst)
        !ale_fall |=> $stable(idx_q));

endmodule

// File: rtl/lbus_regbank.sv
`timescale 1ns/1ps
module lbus_regbank #(
    parameter int NUM_WORDS = 16,
    parameter int DW        = 32,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);
    logic [DW-1:0] words_q [NUM_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                words_q[i] <= '0;
            end
        end else if (wr_en) begin
            words_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = words_q[rd_idx];
endmodule

// File: rtl/lbus_async_slave.sv
`timescale 1ns/1ps
module lbus_async_slave
    import lbus_pkg::*;
#(
    parameter cap_mode_e CAP_MODE      = CAP_SETTLE,
    parameter int        SETTLE_CYCLES = 10,
    parameter int        PIPE_DEPTH    = 4,
    parameter int        LOOKBACK      = 3,
    parameter int        NUM_WORDS     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_ale,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic              bus_cs_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_data_in,
    output logic [BUS_DW-1:0] bus_data_out,
    output logic              bus_data_oe
);
    localparam int        IDX_W     = $clog2(NUM_WORDS);
    localparam int        PIN_W     = $bits(pin_snap_t);
    localparam pin_snap_t IDLE_SNAP = '{ale: 1'b0, we_n: 1'b1, addr: '0, data: '0};

    pin_snap_t                       now_snap;
    logic [PIPE_DEPTH-1:0][PIN_W-1:0] taps_raw;
    pin_snap_t                       taps [PIPE_DEPTH];
    logic                            cs_act;
    logic [IDX_W-1:0]                idx_q;
    logic                            wr_en;
    logic [BUS_DW-1:0]               wr_data;
    logic [BUS_DW-1:0]               rd_word;

    assign now_snap = '{ale: bus_ale, we_n: bus_we_n, addr: bus_addr, data: bus_data_in};

    lbus_sync2 u_cs_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (~bus_cs_n),
        .sync_o  (cs_act)
    );

    lbus_pipe #(
        .W       (PIN_W),
        .DEPTH   (PIPE_DEPTH),
        .RST_VAL (PIN_W'(IDLE_SNAP))
    ) u_pins (
        .clk  (clk),
        .rst  (rst),
        .d    (PIN_W'(now_snap)),
        .taps (taps_raw)
    );

    generate
        for (genvar i = 0; i < PIPE_DEPTH; i++) begin : g_tap
            assign taps[i] = pin_snap_t'(taps_raw[i]);
        end
    endgenerate

    lbus_capture #(
        .MODE          (CAP_MODE),
        .DEPTH         (PIPE_DEPTH),
        .LOOKBACK      (LOOKBACK),
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .IDX_W         (IDX_W)
    ) u_capture (
        .clk     (clk),
        .rst     (rst),
        .cs_act  (cs_act),
        .taps    (taps),
        .idx_q   (idx_q),
        .wr_en   (wr_en),
        .wr_data (wr_data)
    );

    lbus_regbank #(
        .NUM_WORDS (NUM_WORDS),
        .DW        (BUS_DW),
        .IDX_W     (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (idx_q),
        .wr_data (wr_data),
        .rd_idx  (idx_q),
        .rd_data (rd_word)
    );

    // Drive only while the synchronized select agrees with the live pins
    assign bus_data_out = rd_word;
    assign bus_data_oe  = cs_act & ~bus_cs_n & ~bus_oe_n;

    // Independent tally of writes inside one select window
    logic [1:0] wr_tally_q;
    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            wr_tally_q <= '0;
        end else if (wr_en && wr_tally_q != 2'd3) begin
            wr_tally_q <= wr_tally_q + 1'b1;
        end
    end

    // R6: a second write in the same select window never happens
    a_r6_single_write: assert property (@(posedge clk) disable iff (rst)
        (wr_tally_q != 2'd0) |-> !wr_en);

    // R7: select high two edges ago means no write now
    a_r7_no_write_unselected: assert property (@(posedge clk) disable iff (rst)
        $past(bus_cs_n, 2) |-> !wr_en);

    // R10: the driver enable trails the select pin by two flops
    a_r10_sync_delay: assert property (@(posedge clk) disable iff (rst)
        bus_data_oe |-> !$past(bus_cs_n, 2));

endmodule

// File: tb/lbus_async_slave_tb.sv
`timescale 1ns/1ps
module lbus_async_slave_tb;
    import lbus_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ale = 1'b0;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        cs_n = 1'b1;
    logic [23:0] addr = '0;
    logic [31:0] din = '0;
    logic [31:0] dout_s, dout_t;
    logic        oe_s, oe_t;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    lbus_async_slave u_dut (
        .clk (clk), .rst (rst), .bus_ale (ale), .bus_we_n (we_n), .bus_oe_n (oe_n),
        .bus_cs_n (cs_n), .bus_addr (addr), .bus_data_in (din),
        .bus_data_out (dout_s), .bus_data_oe (oe_s)
    );

    lbus_async_slave #(.CAP_MODE(CAP_TRAIL), .PIPE_DEPTH(4), .LOOKBACK(3)) u_dut_trail (
        .clk (clk), .rst (rst), .bus_ale (ale), .bus_we_n (we_n), .bus_oe_n (oe_n),
        .bus_cs_n (cs_n), .bus_addr (addr), .bus_data_in (din),
        .bus_data_out (dout_t), .bus_data_oe (oe_t)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [23:0] a, input logic [31:0] d,
                             input bit swap, input logic [31:0] d2);
        @(negedge clk);
        cs_n = 1'b0; ale = 1'b1; addr = a;
        idle(3);
        ale = 1'b0; addr = 24'hFFFFFF; we_n = 1'b0; din = d;
        idle(8);
        chk("R8 settle no drive while writing", {31'b0, oe_s}, 32'd0);
        chk("R8 trail no drive while writing", {31'b0, oe_t}, 32'd0);
        idle(8);
        if (swap) din = d2;
        idle(6);
        we_n = 1'b1; din = ~d;
        idle(4);
        cs_n = 1'b1;
        idle(4);
    endtask

    task automatic bus_read(input logic [23:0] a, input logic [31:0] exp_s,
                            input logic [31:0] exp_t, input string tag_s, input string tag_t);
        @(negedge clk);
        cs_n = 1'b0; ale = 1'b1; addr = a;
        idle(3);
        ale = 1'b0; addr = 24'h000000; oe_n = 1'b0;
        idle(4);
        chk("R8 settle drive enable", {31'b0, oe_s}, 32'd1);
        chk("R8 trail drive enable", {31'b0, oe_t}, 32'd1);
        chk(tag_s, dout_s, exp_s);
        chk(tag_t, dout_t, exp_t);
        cs_n = 1'b1; oe_n = 1'b1;
        idle(1);
        chk("R9 settle release", {31'b0, oe_s}, 32'd0);
        chk("R9 trail release", {31'b0, oe_t}, 32'd0);
        idle(3);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(2);
        chk("R1 settle oe after reset", {31'b0, oe_s}, 32'd0);
        chk("R1 trail oe after reset", {31'b0, oe_t}, 32'd0);
        bus_read(24'h000003, 32'h0, 32'h0, "R1 settle word zero", "R1 trail word zero");
    endtask

    task automatic t_basic;
        bus_write(24'h000003, 32'hDEADBEEF, 1'b0, 32'h0);
        bus_read(24'h000003, 32'hDEADBEEF, 32'hDEADBEEF, "R4 settle capture", "R5 trail capture");
    endtask

    task automatic t_alias;
        bus_write(24'hABC00A, 32'h12345678, 1'b0, 32'h0);
        bus_read(24'h00000A, 32'h12345678, 32'h12345678, "R3 settle low bits", "R3 trail low bits");
        bus_read(24'h55551A, 32'h12345678, 32'h12345678, "R3 settle high bits ignored", "R3 trail high bits ignored");
    endtask

    task automatic t_addr_hold;
        // Garbage address FFFFFF was on the pins during every data phase
        bus_read(24'h00000F, 32'h0, 32'h0, "R2 settle address held", "R2 trail address held");
    endtask

    task automatic t_long_strobe;
        bus_write(24'h000005, 32'h11111111, 1'b1, 32'h22222222);
        bus_read(24'h000005, 32'h11111111, 32'h22222222, "R6 settle one write on long strobe",
                 "R5 trail three-cycle look-back");
    endtask

    task automatic t_double;
        @(negedge clk);
        cs_n = 1'b0; ale = 1'b1; addr = 24'h000007;
        idle(3);
        ale = 1'b0; addr = 24'hFFFFFF; we_n = 1'b0; din = 32'hA1A1A1A1;
        idle(16);
        we_n = 1'b1;
        idle(3);
        we_n = 1'b0; din = 32'hB2B2B2B2;
        idle(6);
        we_n = 1'b1;
        idle(4);
        cs_n = 1'b1;
        idle(4);
        bus_read(24'h000007, 32'hA1A1A1A1, 32'hA1A1A1A1, "R6 settle second pulse ignored",
                 "R6 trail second pulse ignored");
    endtask

    task automatic t_unselected;
        @(negedge clk);
        ale = 1'b1; addr = 24'h000003;
        idle(3);
        ale = 1'b0; we_n = 1'b0; din = 32'h0BADF00D;
        idle(16);
        we_n = 1'b1;
        idle(4);
        bus_read(24'h000003, 32'hDEADBEEF, 32'hDEADBEEF, "R7 settle unselected write",
                 "R7 trail unselected write");
    endtask

    task automatic t_sync;
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0;
        idle(1);
        chk("R10 settle one edge no drive", {31'b0, oe_s}, 32'd0);
        chk("R10 trail one edge no drive", {31'b0, oe_t}, 32'd0);
        idle(1);
        chk("R10 settle two edges drive", {31'b0, oe_s}, 32'd1);
        chk("R10 trail two edges drive", {31'b0, oe_t}, 32'd1);
        cs_n = 1'b1; oe_n = 1'b1;
        idle(1);
        chk("R9 settle release on select", {31'b0, oe_s}, 32'd0);
        chk("R9 trail release on select", {31'b0, oe_t}, 32'd0);
        idle(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_basic;
        t_alias;
        t_addr_hold;
        t_long_strobe;
        t_double;
        t_unselected;
        t_sync;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule